// File: doc/BRIEF.md
# Indexed Load/Store Address Generator

This block produces the address of a memory access together with the value that a base register may take afterwards. It takes a base value, picks an offset from one of three sources, and adds the offset to the base or subtracts it. The offset is either an immediate, an index register, or an index register shifted left. One of three indexing modes then decides which value becomes the access address and whether the base is updated.

The datapath is combinational. A parameter can place one register stage on all outputs. The block sits between operand read and the memory port of a load/store pipe. The register file and the memory interface belong to the surrounding design. The writeback strobe tells the register file to store the new base.

Top module: `agu_indexed`

## Requirements
- R1: Mode 0 (no update): `ea_o` equals base plus or minus offset, `wb_en_o` is 0, and `new_base_o` equals the unchanged base.
- R2: Mode 1 (update before): `ea_o` and `new_base_o` both equal base plus or minus offset, and `wb_en_o` is 1.
- R3: Mode 2 (update after): `ea_o` equals the unmodified base, `new_base_o` equals base plus or minus offset, and `wb_en_o` is 1.
- R4: Source code 0 selects the immediate, zero-extended from IMM_W (12) bits to 32 bits.
- R5: Source code 1 selects `index_i` unshifted, and `shamt_i` has no effect.
- R6: Source code 2 selects `index_i` shifted left logically by `shamt_i` (0 to 31). Bits shifted past bit 31 are lost.
- R7: `sub_i` = 0 adds the offset to the base, and `sub_i` = 1 subtracts it.
- R8: Address arithmetic wraps modulo 2^32 and raises no flag.
- R9: Mode code 3 behaves as mode 0, and source code 3 behaves as source code 0.
- R10: With OUT_REG = 1 (the default), the outputs appear one clock after the inputs. While `rst_n` is low, all outputs are 0.
- R11: Four mode-2 accesses with an added immediate of 1 from base B, each feeding `new_base_o` back as the next base, give addresses B, B+1, B+2 and B+3 and leave the base at B+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_i | input | 32 | Base register value |
| imm_i | input | 12 | Immediate offset |
| index_i | input | 32 | Index register value |
| shamt_i | input | 5 | Left shift amount for source code 2 |
| src_sel_i | input | 2 | Offset source: 0 immediate, 1 register, 2 shifted register |
| mode_i | input | 2 | Indexing mode: 0 none, 1 update before, 2 update after |
| sub_i | input | 1 | 1 subtracts the offset |
| ea_o | output | 32 | Effective address |
| new_base_o | output | 32 | Base value to write back |
| wb_en_o | output | 1 | Writeback enable |

## Verification
The block keeps no state apart from the output register, so any wrong internal value shows at the ports in the cycle after the inputs that caused it. A faulty shifter stage corrupts the offset only for shift amounts that have that stage's bit set. A swapped mode route shows as `ea_o` and `new_base_o` trading values, or as a wrong writeback strobe. Feeding `new_base_o` back as the next base makes an error persist, so a bad step in the post-update walk is still visible in the final base.

// File: rtl/agu_pkg.sv
package agu_pkg;
   typedef enum logic [1:0] {
      MODE_PLAIN = 2'd0,
      MODE_PRE   = 2'd1,
      MODE_POST  = 2'd2,
      MODE_RSVD  = 2'd3
   } agu_mode_e;

   typedef enum logic [1:0] {
      OFS_IMM    = 2'd0,
      OFS_REG    = 2'd1,
      OFS_REGSHL = 2'd2,
      OFS_RSVD   = 2'd3
   } agu_src_e;
endpackage

// File: rtl/agu_offset_sel.sv
module agu_offset_sel #(
   parameter int ADDR_W  = 32,
   parameter int IMM_W   = 12,
   parameter int SHAMT_W = 5
) (
   input  logic [IMM_W-1:0]   imm_i,
   input  logic [ADDR_W-1:0]  index_i,
   input  logic [SHAMT_W-1:0] shamt_i,
   input  logic [1:0]         src_i,
   output logic [ADDR_W-1:0]  offset_o
);
   import agu_pkg::*;

   localparam int PAD_W = ADDR_W - IMM_W;

   generate
      if (IMM_W > ADDR_W) begin : g_bad_imm
         $error("IMM_W must not exceed ADDR_W");
      end
      if (SHAMT_W != $clog2(ADDR_W)) begin : g_bad_shamt
         $error("SHAMT_W must equal clog2(ADDR_W)");
      end
   endgenerate

   // Logarithmic shifter: stage k moves the value by 2**k when shamt bit k is set.
   logic [ADDR_W-1:0] stage [SHAMT_W+1];
   assign stage[0] = index_i;

   genvar k;
   generate
      for (k = 0; k < SHAMT_W; k++) begin : g_shl
         localparam int DIST = 1 << k;
         assign stage[k+1] = shamt_i[k] ? {stage[k][ADDR_W-1-DIST:0], {DIST{1'b0}}}
                                        : stage[k];
      end
   endgenerate

   logic [ADDR_W-1:0] imm_ext;
   generate
      if (PAD_W > 0) begin : g_pad
         assign imm_ext = {{PAD_W{1'b0}}, imm_i};
      end else begin : g_nopad
         assign imm_ext = imm_i[ADDR_W-1:0];
      end
   endgenerate

   always_comb begin
      unique case (agu_src_e'(src_i))
         OFS_REG:    offset_o = index_i;
         OFS_REGSHL: offset_o = stage[SHAMT_W];
         default:    offset_o = imm_ext;
      endcase
   end
endmodule

// File: rtl/agu_addsub.sv
module agu_addsub #(
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] base_i,
   input  logic [ADDR_W-1:0] offset_i,
   input  logic              sub_i,
   output logic [ADDR_W-1:0] sum_o
);
   generate
      if (ADDR_W < 2) begin : g_bad_w
         $error("ADDR_W too small");
      end
   endgenerate

   // Single adder: subtract as base + ~offset + 1. The carry out is dropped, so the result wraps.
   logic [ADDR_W-1:0] operand;
   logic [ADDR_W:0]   full;
   assign operand = sub_i ? ~offset_i : offset_i;
   assign full    = {1'b0, base_i} + {1'b0, operand} + {{ADDR_W{1'b0}}, sub_i};
   assign sum_o   = full[ADDR_W-1:0];
endmodule

// File: rtl/agu_mode_route.sv
module agu_mode_route #(
   parameter int ADDR_W = 32
) (
   input  logic [1:0]        mode_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [ADDR_W-1:0] sum_i,
   output logic [ADDR_W-1:0] ea_o,
   output logic [ADDR_W-1:0] nb_o,
   output logic              wb_o
);
   import agu_pkg::*;

   always_comb begin
      unique case (agu_mode_e'(mode_i))
         MODE_PRE: begin
            ea_o = sum_i;
            nb_o = sum_i;
            wb_o = 1'b1;
         end
         MODE_POST: begin
            ea_o = base_i;
            nb_o = sum_i;
            wb_o = 1'b1;
         end
         default: begin
            ea_o = sum_i;
            nb_o = base_i;
            wb_o = 1'b0;
         end
      endcase
   end
endmodule

// File: rtl/agu_indexed.sv
module agu_indexed #(
   parameter int ADDR_W  = 32,
   parameter int IMM_W   = 12,
   parameter int SHAMT_W = 5,
   parameter bit OUT_REG = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  base_i,
   input  logic [IMM_W-1:0]   imm_i,
   input  logic [ADDR_W-1:0]  index_i,
   input  logic [SHAMT_W-1:0] shamt_i,
   input  logic [1:0]         src_sel_i,
   input  logic [1:0]         mode_i,
   input  logic               sub_i,
   output logic [ADDR_W-1:0]  ea_o,
   output logic [ADDR_W-1:0]  new_base_o,
   output logic               wb_en_o
);
   import agu_pkg::*;

   logic [ADDR_W-1:0] offset, sum, ea_c, nb_c;
   logic              wb_c;

   agu_offset_sel #(.ADDR_W(ADDR_W), .IMM_W(IMM_W), .SHAMT_W(SHAMT_W)) u_ofs (
      .imm_i(imm_i), .index_i(index_i), .shamt_i(shamt_i),
      .src_i(src_sel_i), .offset_o(offset)
   );

   agu_addsub #(.ADDR_W(ADDR_W)) u_add (
      .base_i(base_i), .offset_i(offset), .sub_i(sub_i), .sum_o(sum)
   );

   agu_mode_route #(.ADDR_W(ADDR_W)) u_route (
      .mode_i(mode_i), .base_i(base_i), .sum_i(sum),
      .ea_o(ea_c), .nb_o(nb_c), .wb_o(wb_c)
   );

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ea_o       <= '0;
               new_base_o <= '0;
               wb_en_o    <= 1'b0;
            end else begin
               ea_o       <= ea_c;
               new_base_o <= nb_c;
               wb_en_o    <= wb_c;
            end
         end

         assert_plain_no_wb_R1: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && ($past(mode_i) == MODE_PLAIN || $past(mode_i) == MODE_RSVD))
               |-> (!wb_en_o && new_base_o == $past(base_i)));
         assert_pre_same_R2: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(mode_i) == MODE_PRE) |-> (wb_en_o && ea_o == new_base_o));
         assert_post_base_R3: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(mode_i) == MODE_POST) |-> (wb_en_o && ea_o == $past(base_i)));
         assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $stable(base_i) && $stable(imm_i) && $stable(index_i) &&
             $stable(shamt_i) && $stable(src_sel_i) && $stable(mode_i) && $stable(sub_i))
               |=> $stable(ea_o));
      end else begin : g_comb
         assign ea_o       = ea_c;
         assign new_base_o = nb_c;
         assign wb_en_o    = wb_c;

         assert_plain_no_wb_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_i == MODE_PLAIN || mode_i == MODE_RSVD) |-> (!wb_en_o && new_base_o == base_i));
         assert_pre_same_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_i == MODE_PRE) |-> (wb_en_o && ea_o == new_base_o));
         assert_post_base_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_i == MODE_POST) |-> (wb_en_o && ea_o == base_i));
      end
   endgenerate
endmodule

// File: tb/agu_indexed_tb.sv
`timescale 1ns/1ps
module agu_indexed_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] base_i = '0;
   logic [11:0] imm_i = '0;
   logic [31:0] index_i = '0;
   logic [4:0]  shamt_i = '0;
   logic [1:0]  src_sel_i = '0;
   logic [1:0]  mode_i = '0;
   logic        sub_i = 1'b0;
   logic [31:0] ea_o, new_base_o;
   logic        wb_en_o;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   agu_indexed u_dut (
      .clk(clk), .rst_n(rst_n), .base_i(base_i), .imm_i(imm_i), .index_i(index_i),
      .shamt_i(shamt_i), .src_sel_i(src_sel_i), .mode_i(mode_i), .sub_i(sub_i),
      .ea_o(ea_o), .new_base_o(new_base_o), .wb_en_o(wb_en_o)
   );

   function automatic logic [64:0] model(logic [31:0] b, logic [11:0] im, logic [31:0] ix,
                                         logic [4:0] sh, logic [1:0] src, logic [1:0] md,
                                         logic sb);
      logic [31:0] ofs, s;
      if (src == 2'd1)      ofs = ix;
      else if (src == 2'd2) ofs = ix << sh;
      else                  ofs = {20'd0, im};
      s = sb ? b - ofs : b + ofs;
      if (md == 2'd1)      return {s, s, 1'b1};
      else if (md == 2'd2) return {b, s, 1'b1};
      else                 return {s, b, 1'b0};
   endfunction

   task automatic check(string tag, logic [64:0] got, logic [64:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got ea=%h nb=%h wb=%b exp ea=%h nb=%h wb=%b", tag,
                  got[64:33], got[32:1], got[0], exp[64:33], exp[32:1], exp[0]);
      end
   endtask

   task automatic apply(logic [31:0] b, logic [11:0] im, logic [31:0] ix, logic [4:0] sh,
                        logic [1:0] src, logic [1:0] md, logic sb, string tag);
      @(negedge clk);
      base_i = b; imm_i = im; index_i = ix; shamt_i = sh;
      src_sel_i = src; mode_i = md; sub_i = sb;
      @(posedge clk);
      @(negedge clk);
      check(tag, {ea_o, new_base_o, wb_en_o}, model(b, im, ix, sh, src, md, sb));
   endtask

   initial begin
      #800000;
      errors++; checks++;
      $display("FAIL watchdog R10 got timeout exp completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] walk;
      int unused;
      unused = $urandom(32'd4242);
      base_i = 32'hDEAD_BEEF; mode_i = 2'd1; imm_i = 12'h5;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R10 reset", {ea_o, new_base_o, wb_en_o}, 65'd0);
      rst_n = 1'b1;

      apply(32'h0000_1000, 12'h010, 0, 0, 2'd0, 2'd0, 1'b0, "R1 R4 plain imm add");
      apply(32'h0000_1000, 12'h010, 0, 0, 2'd0, 2'd1, 1'b0, "R2 pre imm add");
      apply(32'h0000_1000, 12'h010, 0, 0, 2'd0, 2'd2, 1'b1, "R3 R7 post imm sub");
      apply(32'h0000_1000, 12'hFFF, 0, 0, 2'd0, 2'd0, 1'b0, "R4 imm zero-extended");
      apply(32'h2000_0000, 0, 32'h44, 5'd7, 2'd1, 2'd1, 1'b0, "R5 shamt ignored");
      apply(32'h2000_0000, 0, 32'h3, 5'd31, 2'd2, 2'd0, 1'b0, "R6 shift 31");
      apply(32'h2000_0000, 0, 32'h3, 5'd0, 2'd2, 2'd1, 1'b1, "R6 shift 0");
      apply(32'h2000_0000, 0, 32'h1, 5'd12, 2'd2, 2'd2, 1'b0, "R6 shift 12");
      apply(32'hFFFF_FFFF, 12'h1, 0, 0, 2'd0, 2'd1, 1'b0, "R8 wrap up");
      apply(32'h0000_0000, 12'h1, 0, 0, 2'd0, 2'd2, 1'b1, "R8 wrap down");
      apply(32'h0000_0100, 12'h8, 32'h55, 5'd3, 2'd3, 2'd3, 1'b0, "R9 reserved codes");

      walk = 32'h2000_0FFE;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         base_i = walk; imm_i = 12'd1; src_sel_i = 2'd0; mode_i = 2'd2; sub_i = 1'b0;
         @(posedge clk);
         @(negedge clk);
         check("R11 walk address", {ea_o, 32'd0, wb_en_o}, {32'h2000_0FFE + i, 32'd0, 1'b1});
         walk = new_base_o;
      end
      check("R11 final base", {walk, 33'd0}, {32'h2000_1002, 33'd0});

      for (int n = 0; n < 400; n++) begin
         logic [1:0] md;
         md = 2'($urandom);
         apply($urandom, 12'($urandom), $urandom, 5'($urandom), 2'($urandom), md,
               1'($urandom), md == 2'd1 ? "R2 random" : md == 2'd2 ? "R3 random" : "R1 random");
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule